// File: doc/BRIEF.md
# IO-Port Reset Control Decoder

This block is a slave on a legacy PC-style IO port bus. It holds two registers that share one dword of IO space. The dword at ports 0xCF8 to 0xCFB is a 32-bit PCI configuration address register. The single byte at port 0xCF9 is a reset control register. Wherever the two overlap, the byte register wins.

The bus presents a dword address, four byte enables, 32 bits of write data and separate read and write strobes. Each byte lane maps to one port of the dword. Lane 1 carries port 0xCF9, and every lane-1 access goes to the reset control register. Lanes 0, 2 and 3 go to the configuration address register.

A write to the reset control register with its fire bit set produces a one-cycle reset request for the system's reset sequencer. That write stores nothing. Any other write to the reset control register keeps only the reset-type bit, which software can read back. The reset-type bit does not change the block's behaviour in any other way.

Top module: `io_reset_ctl`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the configuration address register, the reset control register, `rst_req` and `io_rdata` all clear to zero.
- R2: A write that hits dword 0xCF8 (`io_addr[15:2]` = 0x33E) updates the configuration address bytes in lanes 0, 2 and 3 whose byte enable is set. Bits 1:0 of the register always read as zero.
- R3: Lane 1 (`io_be[1]`, data bits 15:8) never reaches the configuration address register. Its bits 15:8 stay zero, and a lane-1-only write leaves the other lanes unchanged.
- R4: A hitting lane-1 write whose fire bit (`io_wdata[10]`) is clear stores only the reset-type bit (`io_wdata[9]`) into bit 1 of the reset control register. Every other stored bit is zero.
- R5: A hitting lane-1 write with `io_wdata[10]` set leaves the stored reset control value unchanged.
- R6: `rst_req` is high for exactly the cycle after each clock edge that samples a hitting lane-1 write with `io_wdata[10]` set. It is low in every other cycle, so back-to-back firing writes give one pulse each.
- R7: On the cycle after a read strobe that hits, `io_rdata` carries the configuration address bytes in lanes 0, 2 and 3 and the reset control value in lane 1. Lanes whose byte enable is clear read zero.
- R8: Accesses to any other dword address are ignored. They store nothing, raise no `rst_req`, and read back zero.
- R9: The stored reset-type bit has no effect on `rst_req` or on any other behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | IO address; bits 15:2 select the dword |
| io_be | input | 4 | Byte enables, lane n is port base+n |
| io_wdata | input | 32 | Write data, lane n in bits 8n+7:8n |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 32 | Read data, registered, valid the cycle after `io_rd` |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench aims at the overlap. A full-dword write must split its lanes between the two registers. A design that let lane 1 reach the configuration address register would read back a non-zero byte 1 after the lane-1 write was cleared.

Firing writes are sent both alone and back to back. A design that stored the firing byte, or that merged two pulses into one, shows a wrong lane-1 readback or a missing `rst_req` cycle.

Writes that carry only the reset-type bit, or that have all other bits set, expose a design that keeps more than bit 1 or that fires on the wrong bit. Firing data sent to the neighbouring dword, and a reset applied in mid-run, check that foreign addresses are ignored and that both registers clear.

// File: rtl/io_rst_pkg.sv
package io_rst_pkg;
    localparam int LANES    = 4;
    localparam int DATA_W   = 8 * LANES;
    localparam int RC_LANE  = 1;   // byte lane of the reset control port
    localparam int FIRE_BIT = 2;   // reset request trigger
    localparam int TYPE_BIT = 1;   // soft/hard selector, stored only
    localparam logic [DATA_W-1:0] CFG_KEEP = 32'hFFFF_FFFC;

    typedef struct packed {
        logic             hit;
        logic [LANES-1:0] wr_lane;
        logic [LANES-1:0] rd_lane;
    } io_dec_t;

    function automatic logic [7:0] lane_byte(input logic [DATA_W-1:0] d, input int n);
        return d[8*n +: 8];
    endfunction
endpackage

// File: rtl/io_port_decode.sv
module io_port_decode
    import io_rst_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'h0CF8
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [LANES-1:0]  io_be,
    input  logic              io_wr,
    input  logic              io_rd,
    output io_dec_t           dec
);
    localparam int DW_BITS = ADDR_W - 2;
    localparam logic [DW_BITS-1:0] BASE_DW = BASE[ADDR_W-1:2];

    always_comb begin
        dec.hit     = (io_addr[ADDR_W-1:2] == BASE_DW);
        dec.wr_lane = (dec.hit && io_wr) ? io_be : '0;
        dec.rd_lane = (dec.hit && io_rd) ? io_be : '0;
    end
endmodule

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
    import io_rst_pkg::*;
#(
    parameter logic [LANES-1:0] OWN_LANES = 4'b1101
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANES-1:0]  wr_lane,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cfg_q
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (OWN_LANES[g]) begin : g_own
            logic [7:0] byte_q;
            always_ff @(posedge clk) begin
                if (rst)
                    byte_q <= '0;
                else if (wr_lane[g])
                    byte_q <= lane_byte(wdata, g) & lane_byte(CFG_KEEP, g);
            end
            assign cfg_q[8*g +: 8] = byte_q;
        end else begin : g_lent
            assign cfg_q[8*g +: 8] = '0;
        end
    end
endmodule

// File: rtl/rst_ctl_reg.sv
module rst_ctl_reg
    import io_rst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wbyte,
    output logic [7:0] rcr_q,
    output logic       rst_req
);
    logic fire;
    assign fire = wr_en && wbyte[FIRE_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            rcr_q   <= '0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= fire;
            if (wr_en && !fire) begin
                rcr_q           <= '0;
                rcr_q[TYPE_BIT] <= wbyte[TYPE_BIT];
            end
        end
    end
endmodule

// File: rtl/io_reset_ctl.sv
module io_reset_ctl
    import io_rst_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'h0CF8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [LANES-1:0]  io_be,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [DATA_W-1:0] io_rdata,
    output logic              rst_req
);
    localparam logic [LANES-1:0] CFG_LANES = ~(LANES'(1) << RC_LANE);

    io_dec_t           dec;
    logic [DATA_W-1:0] cfg_q;
    logic [7:0]        rcr_q;
    logic [DATA_W-1:0] rd_view;

    io_port_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .io_addr(io_addr), .io_be(io_be), .io_wr(io_wr), .io_rd(io_rd), .dec(dec)
    );

    cfg_addr_reg #(.OWN_LANES(CFG_LANES)) u_cfg (
        .clk(clk), .rst(rst), .wr_lane(dec.wr_lane), .wdata(io_wdata), .cfg_q(cfg_q)
    );

    rst_ctl_reg u_rcr (
        .clk(clk), .rst(rst),
        .wr_en(dec.wr_lane[RC_LANE]),
        .wbyte(lane_byte(io_wdata, RC_LANE)),
        .rcr_q(rcr_q), .rst_req(rst_req)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_rd
        if (g == RC_LANE) begin : g_rc
            assign rd_view[8*g +: 8] = dec.rd_lane[g] ? rcr_q : 8'h00;
        end else begin : g_cf
            assign rd_view[8*g +: 8] = dec.rd_lane[g] ? cfg_q[8*g +: 8] : 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) io_rdata <= '0;
        else     io_rdata <= rd_view;
    end
endmodule

// File: rtl/io_reset_ctl_chk.sv
module io_reset_ctl_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] io_addr,
    input logic [3:0]  io_be,
    input logic [31:0] io_wdata,
    input logic        io_wr,
    input logic        io_rd,
    input logic [31:0] io_rdata,
    input logic        rst_req,
    input logic [31:0] cfg_q,
    input logic [7:0]  rcr_q
);
    logic hit, fire_wr;
    assign hit     = (io_addr[15:2] == 14'h33E);
    assign fire_wr = io_wr && hit && io_be[1] && io_wdata[10];

    a_r1_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (rcr_q == 8'h00 && cfg_q == 32'h0 && !rst_req && io_rdata == 32'h0));
    a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
        cfg_q[1:0] == 2'b00);
    a_r3_lane1_unused: assert property (@(posedge clk) disable iff (rst)
        cfg_q[15:8] == 8'h00);
    a_r4_type_only: assert property (@(posedge clk) disable iff (rst)
        (rcr_q & 8'hFD) == 8'h00);
    a_r5_fire_no_store: assert property (@(posedge clk) disable iff (rst)
        fire_wr |=> $stable(rcr_q));
    a_r6_req_cause: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $past(fire_wr));
    a_r6_req_follows: assert property (@(posedge clk) disable iff (rst)
        fire_wr |=> rst_req);
    a_r8_miss_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (io_rd && !hit) |=> io_rdata == 32'h0);
endmodule

bind io_reset_ctl io_reset_ctl_chk u_chk (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_be(io_be), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .rst_req(rst_req),
    .cfg_q(cfg_q), .rcr_q(rcr_q)
);

// File: tb/tb_io_reset_ctl.sv
module tb_io_reset_ctl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic [3:0]  io_be = '0;
    logic [31:0] io_wdata = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [31:0] io_rdata;
    logic        rst_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    // reference state built from the requirements
    logic [31:0] m_cfg = '0;
    logic [7:0]  m_rcr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    io_reset_ctl dut (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_be(io_be), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .rst_req(rst_req)
    );

    function automatic bit is_hit(input logic [15:0] a);
        return a[15:2] == 14'h33E;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        io_addr = a; io_be = be; io_wdata = d; io_wr = 1'b1;
        if (is_hit(a)) begin
            for (int n = 0; n < 4; n++)
                if (be[n] && n != 1) m_cfg[8*n +: 8] = d[8*n +: 8];
            m_cfg[1:0] = 2'b00;
            if (be[1] && !d[10]) m_rcr = {6'b0, d[9], 1'b0};
        end
        @(negedge clk);
        io_wr = 1'b0; io_be = '0;
    endtask

    task automatic do_read(input logic [15:0] a, input logic [3:0] be, input string req);
        logic [31:0] e;
        e = '0;
        if (is_hit(a))
            for (int n = 0; n < 4; n++)
                if (be[n]) e[8*n +: 8] = (n == 1) ? m_rcr : m_cfg[8*n +: 8];
        exp_q.push_back(e);
        tag_q.push_back(req);
        @(negedge clk);
        io_addr = a; io_be = be; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0; io_be = '0;
    endtask

    // monitor: read scoreboard and reset-request model (R6)
    always begin
        logic        was_rd, exp_req, was_wr;
        @(posedge clk);
        was_rd  = io_rd && !rst;
        was_wr  = io_wr && !rst;
        exp_req = !rst && io_wr && is_hit(io_addr) && io_be[1] && io_wdata[10];
        #(CLK_PERIOD/4);
        if (was_rd) begin
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R7: actual %h expected none (unexpected read)", io_rdata);
            end else begin
                string t;
                logic [31:0] e;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, io_rdata, e);
            end
        end
        if (was_wr || rst_req) check("R6 rst_req pulse", {31'b0, rst_req}, {31'b0, exp_req});
        else if (rst_req !== 1'b0) check("R6 rst_req idle", {31'b0, rst_req}, 32'h0);
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 rdata after reset", io_rdata, 32'h0);
        check("R1 rst_req after reset", {31'b0, rst_req}, 32'h0);
        do_read(16'h0CF8, 4'hF, "R1 registers zero");

        // full dword write: lanes split between registers
        do_write(16'h0CF8, 4'hF, 32'h80AB_1237);
        do_read(16'h0CF8, 4'hF, "R2/R3/R4 split dword");

        // firing write: pulse, value kept
        do_write(16'h0CF9, 4'h2, 32'h0000_0600);
        do_read(16'h0CF8, 4'h2, "R5 fire keeps value");

        // clear type bit
        do_write(16'h0CF9, 4'h2, 32'h0000_0000);
        do_read(16'h0CF8, 4'hF, "R4 cleared type, R3 cfg intact");

        // all bits except fire set: only bit 1 kept, no request (R9)
        do_write(16'h0CF9, 4'h2, 32'h0000_FB00);
        do_read(16'h0CF8, 4'h2, "R4 only bit1 kept");

        // lane 0 only, low bits forced zero
        do_write(16'h0CF8, 4'h1, 32'hFFFF_FFFF);
        do_read(16'h0CF8, 4'hF, "R2 lane0 write low bits zero");

        // lanes 2 and 3 only
        do_write(16'h0CFA, 4'hC, 32'h1122_3344);
        do_read(16'h0CF8, 4'hF, "R2 upper lanes");
        do_read(16'h0CF8, 4'h5, "R7 partial enables");

        // neighbour dword: ignored
        do_write(16'h0CFC, 4'hF, 32'hFFFF_FFFF);
        do_read(16'h0CF8, 4'hF, "R8 miss write ignored");
        do_read(16'h0CFC, 4'hF, "R8 miss read zero");

        // back-to-back firing writes
        @(negedge clk);
        io_addr = 16'h0CF8; io_be = 4'h2; io_wdata = 32'h0000_0400; io_wr = 1'b1;
        @(negedge clk);
        io_wdata = 32'h0000_0600;
        @(negedge clk);
        io_wr = 1'b0; io_be = '0;
        do_read(16'h0CF8, 4'hF, "R5 back-to-back fire keeps value");

        // mid-run reset
        @(negedge clk);
        rst = 1'b1;
        m_cfg = '0; m_rcr = '0;
        @(negedge clk);
        rst = 1'b0;
        check("R1 rst_req cleared", {31'b0, rst_req}, 32'h0);
        do_read(16'h0CF8, 4'hF, "R1 mid-run reset clears");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R7: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule